// File: doc/BRIEF.md
# Two-Bank Prioritised Interrupt Controller

The block collects interrupt requests from two banks of request sources, 64 sources in each. Every source has its own programmable priority level, a mask bit and a software force bit. From all sources that are pending, unmasked and given a level, the block picks a single winner. It presents the winner's level and vector number to a processor, but only when that level is above the processor's current priority mask.

Software drives a command-style write port. One command writes a source's level. Other commands set or clear one mask bit by source index, and set or clear one force bit by source index. A combinational read port returns the level, the pending state and the mask state of any single source. When the processor takes an interrupt, it pulses an acknowledge strobe. The block then captures the winning vector and level into output registers, which are valid on the following cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every mask bit reads 1, every level and force bit reads 0, irq_req is low and ack_valid, ack_level and ack_vector are 0.
- R2: Command 0 (set level) writes wr_level into the addressed source's level, which rd_level returns afterwards.
- R3: Command 2 (unmask) clears the mask bit of the source at wr_idx in bank wr_bank only; every other mask bit keeps its value.
- R4: Command 1 (mask) sets the mask bit of the source at wr_idx in bank wr_bank only.
- R5: A source's pending state is its hw_req bit (bit bank*64+index) OR its force bit. Command 3 sets the force bit and command 4 clears it.
- R6: A source whose level is 0 never wins, even when it is pending and unmasked.
- R7: Among eligible sources (pending, unmasked, nonzero level), the highest level wins.
- R8: When levels are equal, a source in bank 0 beats any source in bank 1, whatever its index.
- R9: When bank and level are equal, the higher source index wins.
- R10: cur_vector equals (bank+1)*64 + index of the winner, in the range 64 to 191. cur_level is the winner's level. Both are 0 while irq_req is low.
- R11: irq_req is high only when a winner exists and its level is strictly greater than cpu_ipl.
- R12: An ack pulse loads ack_valid, ack_level and ack_vector from irq_req, cur_level and cur_vector, visible one cycle later. Without ack the three outputs hold their values. With no request above the mask, ack gives ack_valid = 0.
- R13: When a request input falls, the winner shown from the next cycle onward no longer includes that source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | 128 | Hardware request lines, bit bank*64+index |
| wr_en | input | 1 | Command write strobe |
| wr_bank | input | 1 | Bank addressed by the command |
| wr_cmd | input | 3 | 0 level, 1 mask, 2 unmask, 3 force, 4 unforce |
| wr_idx | input | 6 | Source index addressed by the command |
| wr_level | input | 3 | Level value for command 0 |
| rd_bank | input | 1 | Bank selected for read-back |
| rd_idx | input | 6 | Source index selected for read-back |
| rd_level | output | 3 | Level of the selected source |
| rd_pending | output | 1 | Pending state of the selected source |
| rd_masked | output | 1 | Mask bit of the selected source |
| cpu_ipl | input | 3 | Processor's current priority mask |
| irq_req | output | 1 | Request presented to the processor |
| cur_level | output | 3 | Level of the presented request |
| cur_vector | output | 8 | Vector of the presented request |
| ack | input | 1 | Acknowledge strobe from the processor |
| ack_valid | output | 1 | Captured request was present |
| ack_level | output | 3 | Captured level |
| ack_vector | output | 8 | Captured vector |

## Verification
An acknowledge and a command that masks the current winner can land in the same cycle. The bench raises ack together with a mask command on the winning source at one clock edge. It then checks two things: the captured vector must be the winner from before the write, and the presented request must already have moved to the next-best source. A request that is withdrawn while another source waits is handled the same way. The winner must change on the cycle after the line falls.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [2:0] {
      CMD_LEVEL   = 3'd0,
      CMD_MASK    = 3'd1,
      CMD_UNMASK  = 3'd2,
      CMD_FORCE   = 3'd3,
      CMD_UNFORCE = 3'd4
   } irqc_cmd_e;
endpackage

// File: rtl/irqc_pick.sv
// Selects the highest-level eligible source of one bank; ties go to the
// higher index because later entries replace on equal level.
module irqc_pick #(
   parameter int SRC   = 64,
   parameter int LVL_W = 3,
   localparam int IDX_W = $clog2(SRC)
) (
   input  logic [SRC-1:0]       elig,
   input  logic [SRC*LVL_W-1:0] lvls,
   output logic                 best_v,
   output logic [LVL_W-1:0]     best_lvl,
   output logic [IDX_W-1:0]     best_idx
);
   always_comb begin
      best_v   = 1'b0;
      best_lvl = '0;
      best_idx = '0;
      for (int i = 0; i < SRC; i++) begin
         if (elig[i] && (!best_v || lvls[i*LVL_W +: LVL_W] >= best_lvl)) begin
            best_v   = 1'b1;
            best_lvl = lvls[i*LVL_W +: LVL_W];
            best_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irqc_bank.sv
// Per-bank source state (level, mask, force) plus its local winner.
module irqc_bank
   import irqc_pkg::*;
#(
   parameter int SRC   = 64,
   parameter int LVL_W = 3,
   localparam int IDX_W = $clog2(SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  irqc_cmd_e        wr_cmd,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [LVL_W-1:0] wr_level,
   input  logic [SRC-1:0]   hw_req,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [LVL_W-1:0] rd_level,
   output logic             rd_pending,
   output logic             rd_masked,
   output logic             best_v,
   output logic [LVL_W-1:0] best_lvl,
   output logic [IDX_W-1:0] best_idx
);
   logic [SRC*LVL_W-1:0] lvl_q;
   logic [SRC-1:0]       mask_q;
   logic [SRC-1:0]       force_q;
   logic [SRC-1:0]       pend;
   logic [SRC-1:0]       elig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q   <= '0;
         mask_q  <= '1;
         force_q <= '0;
      end else if (wr_en) begin
         unique case (wr_cmd)
            CMD_LEVEL:   lvl_q[32'(wr_idx)*LVL_W +: LVL_W] <= wr_level;
            CMD_MASK:    mask_q[wr_idx]  <= 1'b1;
            CMD_UNMASK:  mask_q[wr_idx]  <= 1'b0;
            CMD_FORCE:   force_q[wr_idx] <= 1'b1;
            CMD_UNFORCE: force_q[wr_idx] <= 1'b0;
            default: ;
         endcase
      end
   end

   assign pend = hw_req | force_q;

   for (genvar i = 0; i < SRC; i++) begin : g_elig
      assign elig[i] = pend[i] && !mask_q[i] && (lvl_q[i*LVL_W +: LVL_W] != '0);
   end

   assign rd_level   = lvl_q[32'(rd_idx)*LVL_W +: LVL_W];
   assign rd_pending = pend[rd_idx];
   assign rd_masked  = mask_q[rd_idx];

   irqc_pick #(.SRC(SRC), .LVL_W(LVL_W)) u_pick (
      .elig    (elig),
      .lvls    (lvl_q),
      .best_v  (best_v),
      .best_lvl(best_lvl),
      .best_idx(best_idx)
   );
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_BANKS    = 2,
   parameter int SRC_PER_BANK = 64,
   parameter int LVL_W        = 3,
   localparam int IDX_W  = $clog2(SRC_PER_BANK),
   localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int VEC_W  = $clog2((NUM_BANKS + 1) * SRC_PER_BANK),
   localparam int REQ_W  = NUM_BANKS * SRC_PER_BANK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REQ_W-1:0]  hw_req,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] wr_bank,
   input  logic [2:0]        wr_cmd,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LVL_W-1:0]  wr_level,
   input  logic [BANK_W-1:0] rd_bank,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [LVL_W-1:0]  rd_level,
   output logic              rd_pending,
   output logic              rd_masked,
   input  logic [LVL_W-1:0]  cpu_ipl,
   output logic              irq_req,
   output logic [LVL_W-1:0]  cur_level,
   output logic [VEC_W-1:0]  cur_vector,
   input  logic              ack,
   output logic              ack_valid,
   output logic [LVL_W-1:0]  ack_level,
   output logic [VEC_W-1:0]  ack_vector
);
   if (NUM_BANKS < 1 || SRC_PER_BANK < 2 || LVL_W < 1) begin : g_bad_cfg
      $error("prio_irq_ctrl: illegal parameter set");
   end

   logic             b_v   [NUM_BANKS];
   logic [LVL_W-1:0] b_lvl [NUM_BANKS];
   logic [IDX_W-1:0] b_idx [NUM_BANKS];
   logic [LVL_W-1:0] b_rdl [NUM_BANKS];
   logic             b_rdp [NUM_BANKS];
   logic             b_rdm [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      irqc_bank #(.SRC(SRC_PER_BANK), .LVL_W(LVL_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_en && (32'(wr_bank) == b)),
         .wr_cmd    (irqc_cmd_e'(wr_cmd)),
         .wr_idx    (wr_idx),
         .wr_level  (wr_level),
         .hw_req    (hw_req[b*SRC_PER_BANK +: SRC_PER_BANK]),
         .rd_idx    (rd_idx),
         .rd_level  (b_rdl[b]),
         .rd_pending(b_rdp[b]),
         .rd_masked (b_rdm[b]),
         .best_v    (b_v[b]),
         .best_lvl  (b_lvl[b]),
         .best_idx  (b_idx[b])
      );
   end

   assign rd_level   = b_rdl[rd_bank];
   assign rd_pending = b_rdp[rd_bank];
   assign rd_masked  = b_rdm[rd_bank];

   // Bank merge: walk from the top bank down, replacing on equal level so
   // the lowest-numbered bank keeps a tie.
   logic              win_v;
   logic [LVL_W-1:0]  win_lvl;
   logic [BANK_W-1:0] win_bank;
   logic [IDX_W-1:0]  win_idx;

   always_comb begin
      win_v    = 1'b0;
      win_lvl  = '0;
      win_bank = '0;
      win_idx  = '0;
      for (int b = NUM_BANKS - 1; b >= 0; b--) begin
         if (b_v[b] && (!win_v || b_lvl[b] >= win_lvl)) begin
            win_v    = 1'b1;
            win_lvl  = b_lvl[b];
            win_bank = BANK_W'(b);
            win_idx  = b_idx[b];
         end
      end
   end

   logic [VEC_W-1:0] win_vec;
   assign win_vec    = VEC_W'((32'(win_bank) + 1) * SRC_PER_BANK + 32'(win_idx));
   assign irq_req    = win_v && (win_lvl > cpu_ipl);
   assign cur_level  = irq_req ? win_lvl : '0;
   assign cur_vector = irq_req ? win_vec : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_valid  <= 1'b0;
         ack_level  <= '0;
         ack_vector <= '0;
      end else if (ack) begin
         ack_valid  <= irq_req;
         ack_level  <= cur_level;
         ack_vector <= cur_vector;
      end
   end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int NUM_BANKS    = 2,
   parameter int SRC_PER_BANK = 64,
   parameter int LVL_W        = 3,
   parameter int VEC_W        = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] cpu_ipl,
   input logic             irq_req,
   input logic [LVL_W-1:0] cur_level,
   input logic [VEC_W-1:0] cur_vector,
   input logic             ack,
   input logic             ack_valid,
   input logic [LVL_W-1:0] ack_level,
   input logic [VEC_W-1:0] ack_vector
);
   // R11
   a_r11_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (cur_level > cpu_ipl));
   // R6
   a_r6_no_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (cur_level != '0));
   // R10
   a_r10_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (32'(cur_vector) >= SRC_PER_BANK &&
                   32'(cur_vector) < (NUM_BANKS + 1) * SRC_PER_BANK));
   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (cur_vector == '0 && cur_level == '0));
   // R12
   a_r12_ack_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (ack_valid == $past(irq_req) && ack_vector == $past(cur_vector)
               && ack_level == $past(cur_level)));
   a_r12_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> ($stable(ack_valid) && $stable(ack_vector) && $stable(ack_level)));
endmodule

bind prio_irq_ctrl irqc_checker #(
   .NUM_BANKS(NUM_BANKS), .SRC_PER_BANK(SRC_PER_BANK),
   .LVL_W(LVL_W), .VEC_W(VEC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_ipl(cpu_ipl), .irq_req(irq_req),
   .cur_level(cur_level), .cur_vector(cur_vector), .ack(ack),
   .ack_valid(ack_valid), .ack_level(ack_level), .ack_vector(ack_vector)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] hw_req = '0;
   logic         wr_en = 1'b0;
   logic [0:0]   wr_bank = '0;
   logic [2:0]   wr_cmd = '0;
   logic [5:0]   wr_idx = '0;
   logic [2:0]   wr_level = '0;
   logic [0:0]   rd_bank = '0;
   logic [5:0]   rd_idx = '0;
   logic [2:0]   rd_level;
   logic         rd_pending, rd_masked;
   logic [2:0]   cpu_ipl = '0;
   logic         irq_req;
   logic [2:0]   cur_level;
   logic [7:0]   cur_vector;
   logic         ack = 1'b0;
   logic         ack_valid;
   logic [2:0]   ack_level;
   logic [7:0]   ack_vector;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   prio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .wr_en(wr_en),
      .wr_bank(wr_bank), .wr_cmd(wr_cmd), .wr_idx(wr_idx), .wr_level(wr_level),
      .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_level(rd_level),
      .rd_pending(rd_pending), .rd_masked(rd_masked), .cpu_ipl(cpu_ipl),
      .irq_req(irq_req), .cur_level(cur_level), .cur_vector(cur_vector),
      .ack(ack), .ack_valid(ack_valid), .ack_level(ack_level),
      .ack_vector(ack_vector)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cmd(input int b, input int c, input int i, input int l);
      @(negedge clk);
      wr_en = 1'b1; wr_bank = 1'(b); wr_cmd = 3'(c); wr_idx = 6'(i); wr_level = 3'(l);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int b, input int i);
      rd_bank = 1'(b); rd_idx = 6'(i); #1;
   endtask

   task automatic chk_win(input string req, input logic v, input int lvl, input int vec);
      #1;
      chk(req, "irq_req", 32'(irq_req), 32'(v));
      chk(req, "cur_level", 32'(cur_level), 32'(lvl));
      chk(req, "cur_vector", 32'(cur_vector), 32'(vec));
   endtask

   // enable a forced source at given level
   task automatic arm(input int b, input int i, input int l);
      cmd(b, 0, i, l);
      cmd(b, 2, i, 0);
      cmd(b, 3, i, 0);
   endtask

   task automatic t_reset;
      rd(0, 0);  chk("R1", "masked b0/0", 32'(rd_masked), 1);
      chk("R1", "level b0/0", 32'(rd_level), 0);
      rd(1, 63); chk("R1", "masked b1/63", 32'(rd_masked), 1);
      chk("R1", "pending b1/63", 32'(rd_pending), 0);
      chk("R1", "irq_req", 32'(irq_req), 0);
      chk("R1", "ack_valid", 32'(ack_valid), 0);
      chk("R1", "ack_vector", 32'(ack_vector), 0);
   endtask

   task automatic t_level_rw;
      cmd(1, 0, 5, 6);
      rd(1, 5); chk("R2", "level b1/5", 32'(rd_level), 6);
      rd(0, 5); chk("R2", "level b0/5 untouched", 32'(rd_level), 0);
      cmd(1, 0, 5, 0);
   endtask

   task automatic t_mask;
      cmd(0, 2, 10, 0);
      rd(0, 10); chk("R3", "masked b0/10", 32'(rd_masked), 0);
      rd(0, 11); chk("R3", "masked b0/11", 32'(rd_masked), 1);
      rd(0, 9);  chk("R3", "masked b0/9", 32'(rd_masked), 1);
      rd(1, 10); chk("R3", "masked b1/10", 32'(rd_masked), 1);
      cmd(0, 1, 10, 0);
      rd(0, 10); chk("R4", "masked b0/10 again", 32'(rd_masked), 1);
   endtask

   task automatic t_force;
      cmd(0, 3, 3, 0);
      rd(0, 3); chk("R5", "forced pending", 32'(rd_pending), 1);
      @(negedge clk); hw_req[4] = 1'b1;
      rd(0, 4); chk("R5", "hw pending", 32'(rd_pending), 1);
      @(negedge clk); hw_req[4] = 1'b0;
      cmd(0, 4, 3, 0);
      rd(0, 3); chk("R5", "unforced pending", 32'(rd_pending), 0);
   endtask

   task automatic t_level0;
      cmd(0, 2, 3, 0);
      cmd(0, 3, 3, 0);
      chk_win("R6", 1'b0, 0, 0);
      cmd(0, 0, 3, 2);
      chk_win("R6", 1'b1, 2, 67);
   endtask

   task automatic t_order;
      arm(1, 2, 5);
      chk_win("R7", 1'b1, 5, 130);
      arm(0, 1, 5);
      chk_win("R8", 1'b1, 5, 65);
      arm(0, 40, 5);
      chk_win("R9", 1'b1, 5, 104);
      arm(1, 63, 7);
      chk_win("R10", 1'b1, 7, 191);
   endtask

   task automatic t_ipl;
      @(negedge clk); cpu_ipl = 3'd7;
      chk_win("R11", 1'b0, 0, 0);
      @(negedge clk); cpu_ipl = 3'd6;
      chk_win("R11", 1'b1, 7, 191);
      cmd(1, 4, 63, 0);
      @(negedge clk); cpu_ipl = 3'd5;
      chk_win("R11", 1'b0, 0, 0);
      @(negedge clk); cpu_ipl = 3'd4;
      chk_win("R11", 1'b1, 5, 104);
   endtask

   task automatic t_ack;
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      chk("R12", "ack_valid", 32'(ack_valid), 1);
      chk("R12", "ack_level", 32'(ack_level), 5);
      chk("R12", "ack_vector", 32'(ack_vector), 104);
      arm(1, 63, 7);
      chk("R12", "ack_vector held", 32'(ack_vector), 104);
      cmd(1, 4, 63, 0);
      @(negedge clk); cpu_ipl = 3'd7; ack = 1'b1;
      @(negedge clk); ack = 1'b0; cpu_ipl = 3'd0;
      chk("R12", "ack_valid none", 32'(ack_valid), 0);
      chk("R12", "ack_vector none", 32'(ack_vector), 0);
   endtask

   task automatic t_withdraw;
      cmd(0, 0, 50, 6);
      cmd(0, 2, 50, 0);
      @(negedge clk); hw_req[50] = 1'b1;
      chk_win("R13", 1'b1, 6, 114);
      @(negedge clk); hw_req[50] = 1'b0;
      @(negedge clk);
      chk_win("R13", 1'b1, 5, 104);
   endtask

   task automatic t_collide;
      @(negedge clk);
      ack = 1'b1; wr_en = 1'b1; wr_bank = 1'b0; wr_cmd = 3'd1; wr_idx = 6'd40;
      @(negedge clk);
      ack = 1'b0; wr_en = 1'b0;
      chk("R12", "collide ack_vector", 32'(ack_vector), 104);
      chk_win("R4", 1'b1, 5, 65);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_level_rw();
      t_mask();
      t_force();
      t_level0();
      t_order();
      t_ipl();
      t_ack();
      t_withdraw();
      t_collide();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule